// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns a stream of 4-bit decimal digits into Excess-3 code one bit at a time. Each digit enters on a single serial line, least significant bit first, with one bit per clock while a qualifier is high. The matching Excess-3 bit appears on the output in the same cycle as the input bit it belongs to, so the output is a Mealy function of the current input and the stored state.

Three flip-flops hold the state. Two of them form a four-step ring that marks which bit of the digit is present. The third holds the running carry of the add-three operation, folded into the form the output gate needs. After the fourth bit of a digit the state is back at its starting value, so digits can follow one another with no idle cycle. While the qualifier is low the state is frozen, so a digit may be spread over any number of cycles.

Top module: `bcdx3_serial`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets all three state bits to 0. The next qualified bit is then treated as bit 0 of a new digit, even if reset came in the middle of a digit.
- R2: While bit_vld is low, bit_out is 0 whatever bit_in holds.
- R3: While bit_vld is high, bit_out equals bit_in XNOR the carry-state bit, in the same cycle. For bit 0 of a digit this is the inverse of bit_in.
- R4: The two position flip-flops (p1,p2) advance once per qualified bit with p1+ = NOT p2 and p2+ = p1. This gives the order 00, 10, 11, 01 for bit positions 0 to 3.
- R5: The carry-state bit c follows c+ = p1·p2·c + NOT(x)·p1·NOT(c) + x·NOT(p1)·NOT(p2). At bit 0 this loads the input bit itself.
- R6: A cycle with bit_vld low leaves all three state bits unchanged.
- R7: For every 4-bit input value d sent LSB first, the four qualified output bits, read LSB first, equal (d + 3) mod 16. For BCD digits 0 to 9 this is the Excess-3 code.
- R8: After the fourth qualified bit the state is 000 again, so the next digit may start in the very next cycle.
- R9: Idle cycles inserted between the bits of a digit do not change that digit's converted result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial BCD data, least significant bit first |
| bit_vld | input | 1 | High when bit_in carries a digit bit |
| bit_out | output | 1 | Serial Excess-3 data, valid in the same cycle as bit_in |

## Verification
A wrong position state shows up within one digit. A bit is then added with the wrong addend or carry rule, so the converted value is off for at least one input digit, and every later digit stays misaligned until reset. A wrong carry bit shows up on bit_out in the very cycle it is used, because the output is a direct XNOR of the input with that bit. Sweeping all sixteen 4-bit values back to back, and again with idle gaps and a mid-digit reset, therefore exposes a fault within a few clocks of its cause.

// File: rtl/bcdx3_pkg.sv
package bcdx3_pkg;

  localparam int DIGIT_W = 4;
  localparam int POS_W   = $clog2(DIGIT_W);

  typedef struct packed {
    logic p1;
    logic p2;
  } phase_t;

  localparam phase_t PHASE_START = '{p1: 1'b0, p2: 1'b0};

  // ring step: 00 -> 10 -> 11 -> 01 -> 00
  function automatic phase_t phase_step(phase_t cur);
    phase_t nxt;
    nxt.p1 = ~cur.p2;
    nxt.p2 = cur.p1;
    return nxt;
  endfunction

  // bit position carried by a ring state
  function automatic logic [POS_W-1:0] phase_index(phase_t cur);
    logic [POS_W-1:0] idx;
    unique case ({cur.p1, cur.p2})
      2'b00:   idx = 2'd0;
      2'b10:   idx = 2'd1;
      2'b11:   idx = 2'd2;
      default: idx = 2'd3;
    endcase
    return idx;
  endfunction

  // next value of the carry-state bit
  function automatic logic carry_step(logic x, phase_t cur, logic c);
    return (cur.p1 & cur.p2 & c)
         | (~x & cur.p1 & ~c)
         | (x & ~cur.p1 & ~cur.p2);
  endfunction

  // serial code bit produced for one input bit
  function automatic logic code_bit(logic x, logic c);
    return ~(x ^ c);
  endfunction

endpackage

// File: rtl/bcdx3_phase.sv
module bcdx3_phase
  import bcdx3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output phase_t           phase,
  output logic [POS_W-1:0] pos,
  output logic             last_bit
);

  phase_t phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PHASE_START;
    end else if (adv) begin
      phase_q <= phase_step(phase_q);
    end
  end

  assign phase    = phase_q;
  assign pos      = phase_index(phase_q);
  assign last_bit = adv && (pos == POS_W'(DIGIT_W - 1));

  // R1: reset returns the ring to the bit-0 state
  assert_phase_reset_R1: assert property (@(posedge clk)
    rst |=> (pos == '0));

  // R4: one position forward per qualified bit
  assert_phase_order_R4: assert property (@(posedge clk) disable iff (rst)
    adv |=> (pos == POS_W'($past(pos) + 1'b1)));

  // R6: ring frozen while not qualified
  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(phase_q));

endmodule

// File: rtl/bcdx3_carry.sv
module bcdx3_carry
  import bcdx3_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   adv,
  input  logic   x,
  input  phase_t phase,
  output logic   c
);

  logic             c_q;
  logic [POS_W-1:0] pos_here;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= 1'b0;
    end else if (adv) begin
      c_q <= carry_step(x, phase, c_q);
    end
  end

  assign c        = c_q;
  assign pos_here = phase_index(phase);

  // R5: after bit 0 the carry state holds that input bit
  assert_carry_load_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && pos_here == '0) |=> (c_q == $past(x)));

  // R8: digit end clears the carry state
  assert_carry_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (adv && pos_here == POS_W'(DIGIT_W - 1)) |=> !c_q);

  // R6: carry state frozen while not qualified
  assert_carry_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(c_q));

endmodule

// File: rtl/bcdx3_emit.sv
module bcdx3_emit
  import bcdx3_pkg::*;
(
  input  logic x,
  input  logic vld,
  input  logic c,
  output logic y
);

  always_comb begin
    y = 1'b0;
    if (vld) begin
      y = code_bit(x, c);
    end
  end

endmodule

// File: rtl/bcdx3_serial.sv
module bcdx3_serial
  import bcdx3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic bit_out
);

  phase_t           phase;
  logic [POS_W-1:0] pos;
  logic             last_bit;
  logic             carry_st;

  bcdx3_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .adv      (bit_vld),
    .phase    (phase),
    .pos      (pos),
    .last_bit (last_bit)
  );

  bcdx3_carry u_carry (
    .clk   (clk),
    .rst   (rst),
    .adv   (bit_vld),
    .x     (bit_in),
    .phase (phase),
    .c     (carry_st)
  );

  bcdx3_emit u_emit (
    .x   (bit_in),
    .vld (bit_vld),
    .c   (carry_st),
    .y   (bit_out)
  );

  // R2: idle cycles drive a low output
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |-> !bit_out);

  // R3: bit 0 of a digit comes out inverted
  assert_first_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && pos == '0) |-> (bit_out == !bit_in));

  // R8: the cycle after a digit's last bit starts a fresh digit
  assert_digit_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    last_bit |=> (pos == '0 && !carry_st));

endmodule

// File: tb/bcdx3_serial_test.sv
module bcdx3_serial_test;

  localparam time CLK_P = 4ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_out;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  bcdx3_serial uut (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (bit_in),
    .bit_vld (bit_vld),
    .bit_out (bit_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one idle cycle, output must stay low (R2)
  task automatic idle_cycle(input logic junk);
    @(negedge clk);
    bit_vld = 1'b0;
    bit_in  = junk;
    #1;
    check("R2 idle output", int'(bit_out), 0);
  endtask

  // send one digit LSB first, gap idle cycles after each bit
  task automatic send_digit(input int d, input int gap, input string req);
    int res;
    int expv;
    res  = 0;
    expv = (d + 3) % 16;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      bit_vld = 1'b1;
      bit_in  = d[k];
      #1;
      check("R3 R5 serial bit", int'(bit_out), (expv >> k) & 1);
      res = res | (int'(bit_out) << k);
      for (int g = 0; g < gap; g++) idle_cycle(logic'((g + k) & 1));
    end
    check(req, res, expv);
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: after reset output idle, first bit is bit 0 (inverted)
    idle_cycle(1'b1);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = 1'b0;
    #1;
    check("R1 first bit after reset", int'(bit_out), 1);
    @(negedge clk);
    bit_vld = 1'b0;
    rst     = 1'b1;
    @(negedge clk);
    rst     = 1'b0;

    // R7 R8 R4: all 16 values back to back, no idle
    for (int d = 0; d < 16; d++) send_digit(d, 0, "R7 R8 R4 digit value");

    // R9 R6: BCD digits with growing gaps
    for (int d = 0; d < 10; d++) send_digit(d, 1 + (d % 3), "R9 R6 gapped digit");

    // R1: reset in mid digit, then a clean conversion
    for (int d = 0; d < 16; d++) begin
      @(negedge clk);
      bit_vld = 1'b1;
      bit_in  = 1'b1;
      @(negedge clk);
      bit_in  = d[0];
      if (d[1]) begin
        @(negedge clk);
        bit_in = 1'b0;
      end
      @(negedge clk);
      bit_vld = 1'b0;
      rst     = 1'b1;
      @(negedge clk);
      rst     = 1'b0;
      send_digit(d, d % 2, "R1 digit after mid reset");
    end

    // R7: descending sweep back to back
    for (int d = 15; d >= 0; d--) send_digit(d, 0, "R7 descending");

    @(negedge clk);
    bit_vld = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule